// File: doc/BRIEF.md
# Address Sequence Command Decoder

This block sits beside a parallel memory bus and watches the stream of read cycles for a fixed six-step address pattern that carries control commands. Five prefix reads must arrive in order, and the sixth read address selects one of four commands: store, recall, auto-store disable and auto-store enable. When the pattern completes, the block emits a one-clock command pulse with a two-bit code. The block that executes the command is not part of this design.

The bus strobes arrive asynchronously and pass through a synchronizer. Only a middle slice of the address takes part in the comparison, and every other address bit is a don't-care. Any write, or any read of an address that breaks the pattern, drops the sequence. After a command is issued, a processing lockout runs for a parameterised number of clocks, and bus cycles are ignored during that time. Store and recall carry an extra transfer interval on top of the base time. A busy flag shows that a sequence is partly entered.

Top module: `seq_cmd_decoder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cmd_valid`, `seq_busy` and `lockout` are 0 and `cmd_code` is 0.
- R2: Only address bits [14:2] are compared. Changing any other address bit has no effect on the outcome of a sequence.
- R3: The masked reads 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, followed by one command read, give exactly one `cmd_valid` pulse of one cycle. The command codes are 0 for store (0x8FC0), 1 for recall (0x4C63), 2 for auto-store disable (0x8B45) and 3 for auto-store enable (0x4B46). The pulse is high in the cycle after the (SYNC_STAGES+1)-th rising clock edge that follows the start of the bus cycle. `cmd_code` holds its value until the next command.
- R4: A bus cycle that begins with `bus_wr_n` low aborts the sequence at any step. No pulse follows, and `seq_busy` is 0 afterwards.
- R5: A read whose address is not the expected prefix aborts the sequence. If that address equals the first prefix value, the sequence restarts at step one.
- R6: A sixth read that matches none of the four command codes gives no pulse and returns the decoder to idle, or to step one when the address equals the first prefix.
- R7: A bus cycle starts on a falling `bus_sel_n`, or on a falling `bus_outen_n` or `bus_wr_n` while `bus_sel_n` stays low. `bus_outen_n` need not be low for a read to count. Address changes while the strobes stay steady start no cycle.
- R8: `seq_busy` is 1 exactly while at least one prefix read has been accepted and the sequence has neither completed nor aborted.
- R9: `lockout` rises together with `cmd_valid`. It stays high for PROC_CYCLES clocks after the auto-store commands and for PROC_CYCLES+XFER_CYCLES clocks after store or recall. Bus cycles that start while it is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel_n | input | 1 | Bus select strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_outen_n | input | 1 | Output enable strobe, active low |
| bus_addr | input | ADDR_W | Bus address |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 2 | Command code of the latest pulse |
| seq_busy | output | 1 | Sequence partly entered |
| lockout | output | 1 | Command processing window active |

## Verification
The bench builds the block with a two-stage synchronizer, PROC_CYCLES of 6 and XFER_CYCLES of 9. These short windows let a following sequence start inside a running lockout and finish after it, so the ignore rule is exercised at the moment the window closes. They also make the long and short lockout lengths directly countable. The 20-bit address lets the bench set bits on both sides of the compared slice, and the shallow synchronizer keeps the pulse latency small enough to confirm cycle by cycle against the reference model.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  localparam int NUM_CMDS = 4;
  localparam int CMD_W    = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_STORE  = 2'd0,
    CMD_RECALL = 2'd1,
    CMD_AS_OFF = 2'd2,
    CMD_AS_ON  = 2'd3
  } cmd_e;

  // entry 0 is the first read of the sequence
  localparam logic [4:0][15:0] DEF_PREFIX = {
    16'h703F, 16'h7C1F, 16'h83E0, 16'hB1C7, 16'h4E38
  };

  // entry index equals the command code
  localparam logic [NUM_CMDS-1:0][15:0] DEF_CMDS = {
    16'h4B46, 16'h8B45, 16'h4C63, 16'h8FC0
  };

endpackage

// File: rtl/seq_sync_edge.sv
module seq_sync_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int KEY_W       = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             outen_n,
  input  logic [KEY_W-1:0] key_in,
  output logic             ev_start,
  output logic             ev_write,
  output logic [KEY_W-1:0] key_s
);

  localparam int VEC_W = KEY_W + 3;
  localparam logic [VEC_W-1:0] IDLE_V = {3'b111, {KEY_W{1'b0}}};

  logic [VEC_W-1:0] stage [SYNC_STAGES];
  logic [VEC_W-1:0] prev_q;
  logic [VEC_W-1:0] cur;
  logic c_sel, c_wr, c_oe, p_sel, p_wr, p_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= IDLE_V;
      prev_q <= IDLE_V;
    end else begin
      stage[0] <= {sel_n, wr_n, outen_n, key_in};
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
      prev_q <= stage[SYNC_STAGES-1];
    end
  end

  assign cur   = stage[SYNC_STAGES-1];
  assign c_sel = cur[VEC_W-1];
  assign c_wr  = cur[VEC_W-2];
  assign c_oe  = cur[VEC_W-3];
  assign p_sel = prev_q[VEC_W-1];
  assign p_wr  = prev_q[VEC_W-2];
  assign p_oe  = prev_q[VEC_W-3];

  // new bus cycle: select falls, or a second strobe falls under a held select
  assign ev_start = (p_sel & ~c_sel) |
                    (~p_sel & ~c_sel & ((p_oe & ~c_oe) | (p_wr & ~c_wr)));
  assign ev_write = ~c_wr;
  assign key_s    = cur[KEY_W-1:0];

endmodule

// File: rtl/seq_matcher.sv
module seq_matcher #(
  parameter int KEY_LO     = 2,
  parameter int KEY_W      = 13,
  parameter int PREFIX_LEN = 5,
  parameter int NUM_CMDS   = 4,
  parameter int PAT_W      = 16,
  parameter logic [PREFIX_LEN-1:0][PAT_W-1:0] PREFIX_PAT = '0,
  parameter logic [NUM_CMDS-1:0][PAT_W-1:0]   CMD_PAT    = '0
) (
  input  logic [KEY_W-1:0]      key,
  output logic [PREFIX_LEN-1:0] pre_hit,
  output logic [NUM_CMDS-1:0]   cmd_hit
);

  for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_pre
    assign pre_hit[i] = (key == PREFIX_PAT[i][KEY_LO +: KEY_W]);
  end

  for (genvar j = 0; j < NUM_CMDS; j++) begin : g_cmd
    assign cmd_hit[j] = (key == CMD_PAT[j][KEY_LO +: KEY_W]);
  end

endmodule

// File: rtl/seq_lockout.sv
module seq_lockout #(
  parameter int SHORT_CYC = 12500,
  parameter int LONG_CYC  = 1012500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic long_op,
  output logic busy
);

  localparam int CNT_W = $clog2(LONG_CYC + 1);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYC);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (load)              cnt_nx = long_op ? LONG_V : SHORT_V;
    else if (cnt_q != '0)  cnt_nx = cnt_q - 1'b1;
    else                   cnt_nx = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      busy  <= (cnt_nx != '0);
    end
  end

endmodule

// File: rtl/seq_cmd_decoder.sv
module seq_cmd_decoder
  import nvseq_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int KEY_LO      = 2,
  parameter int KEY_W       = 13,
  parameter int SYNC_STAGES = 2,
  parameter int PREFIX_LEN  = 5,
  parameter int PAT_W       = 16,
  parameter int PROC_CYCLES = 12500,
  parameter int XFER_CYCLES = 1000000,
  parameter logic [PREFIX_LEN-1:0][PAT_W-1:0] PREFIX_PAT = DEF_PREFIX,
  parameter logic [NUM_CMDS-1:0][PAT_W-1:0]   CMD_PAT    = DEF_CMDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel_n,
  input  logic              bus_wr_n,
  input  logic              bus_outen_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code,
  output logic              seq_busy,
  output logic              lockout
);

  localparam int STEP_W = $clog2(PREFIX_LEN + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);
  localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);
  localparam logic [ADDR_W-1:0] KEY_MASK  =
    ADDR_W'(((64'd1 << KEY_W) - 64'd1) << KEY_LO);

  logic              ev_start, ev_write;
  logic [KEY_W-1:0]  key_s;
  logic [PREFIX_LEN-1:0] pre_hit;
  logic [NUM_CMDS-1:0]   cmd_hit;
  logic [STEP_W-1:0] step_q, step_nx;
  logic              exp_hit, issue, long_op, any_cmd;
  logic [CMD_W-1:0]  cmd_idx;
  logic              addr_unused;

  assign addr_unused = ^(bus_addr & ~KEY_MASK);

  seq_sync_edge #(
    .SYNC_STAGES(SYNC_STAGES),
    .KEY_W      (KEY_W)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sel_n   (bus_sel_n),
    .wr_n    (bus_wr_n),
    .outen_n (bus_outen_n),
    .key_in  (bus_addr[KEY_LO +: KEY_W]),
    .ev_start(ev_start),
    .ev_write(ev_write),
    .key_s   (key_s)
  );

  seq_matcher #(
    .KEY_LO    (KEY_LO),
    .KEY_W     (KEY_W),
    .PREFIX_LEN(PREFIX_LEN),
    .NUM_CMDS  (NUM_CMDS),
    .PAT_W     (PAT_W),
    .PREFIX_PAT(PREFIX_PAT),
    .CMD_PAT   (CMD_PAT)
  ) u_match (
    .key    (key_s),
    .pre_hit(pre_hit),
    .cmd_hit(cmd_hit)
  );

  always_comb begin
    cmd_idx = '0;
    for (int i = 0; i < NUM_CMDS; i++) begin
      if (cmd_hit[i]) cmd_idx = CMD_W'(i);
    end
  end

  assign any_cmd = |cmd_hit;
  assign long_op = (cmd_e'(cmd_idx) == CMD_STORE) || (cmd_e'(cmd_idx) == CMD_RECALL);

  always_comb begin
    exp_hit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step_q == STEP_W'(i)) exp_hit = pre_hit[i];
    end
  end

  always_comb begin
    step_nx = step_q;
    issue   = 1'b0;
    if (ev_start && !lockout) begin
      if (ev_write) begin
        step_nx = '0;
      end else if (step_q == LAST_STEP) begin
        issue   = any_cmd;
        step_nx = (!any_cmd && pre_hit[0]) ? ONE_STEP : '0;
      end else if (exp_hit) begin
        step_nx = step_q + 1'b1;
      end else begin
        step_nx = pre_hit[0] ? ONE_STEP : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q    <= '0;
      seq_busy  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_STORE;
    end else begin
      step_q    <= step_nx;
      seq_busy  <= (step_nx != '0);
      cmd_valid <= issue;
      if (issue) cmd_code <= cmd_idx;
    end
  end

  seq_lockout #(
    .SHORT_CYC(PROC_CYCLES),
    .LONG_CYC (PROC_CYCLES + XFER_CYCLES)
  ) u_lock (
    .clk    (clk),
    .rst    (rst),
    .load   (issue),
    .long_op(long_op),
    .busy   (lockout)
  );

endmodule

// File: rtl/seq_cmd_decoder_chk.sv
module seq_cmd_decoder_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic seq_busy,
  input logic lockout,
  input logic ev_start,
  input logic ev_write
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!cmd_valid && !seq_busy && !lockout));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  p_pulse_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(seq_busy));

  p_write_aborts_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_start && ev_write) |=> !seq_busy);

  p_busy_ends_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !seq_busy);

  p_lock_with_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(lockout) |-> cmd_valid);

  p_idle_in_lock_r9: assert property (@(posedge clk) disable iff (rst)
    lockout |-> !seq_busy);

endmodule

bind seq_cmd_decoder seq_cmd_decoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .seq_busy (seq_busy),
  .lockout  (lockout),
  .ev_start (ev_start),
  .ev_write (ev_write)
);

// File: tb/seq_cmd_decoder_test.sv
module seq_cmd_decoder_test;

  localparam int AW = 20;
  localparam int SS = 2;
  localparam int PC = 6;
  localparam int XC = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic cmd_valid, seq_busy, lockout;
  logic [1:0] cmd_code;

  always #4 clk = ~clk;

  seq_cmd_decoder #(
    .ADDR_W(AW), .SYNC_STAGES(SS), .PROC_CYCLES(PC), .XFER_CYCLES(XC)
  ) uut (
    .clk(clk), .rst(rst), .bus_sel_n(sel_n), .bus_wr_n(wr_n),
    .bus_outen_n(oe_n), .bus_addr(addr), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .seq_busy(seq_busy), .lockout(lockout)
  );

  int pre [5] = '{'h4E38, 'hB1C7, 'h83E0, 'h7C1F, 'h703F};
  int cmds[4] = '{'h8FC0, 'h4C63, 'h8B45, 'h4B46};

  int checks = 0, errors = 0;
  int pulses = 0, last_code = -1, lock_cnt = 0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct packed { logic s; logic w; logic o; logic [AW-1:0] a; } smp_t;
  localparam smp_t IDLE = '{s: 1'b1, w: 1'b1, o: 1'b1, a: '0};

  smp_t q[$];
  smp_t pv;
  int m_step = 0, m_lock = 0, m_code = 0;
  bit m_valid = 1'b0;

  function automatic int kf(int v);
    return (v >> 2) & 'h1FFF;
  endfunction

  always @(posedge clk) begin
    smp_t cur;
    bit ev, lk;
    int k, hit;
    if (rst) begin
      q.delete();
      for (int i = 0; i < SS; i++) q.push_back(IDLE);
      pv = IDLE; m_step = 0; m_lock = 0; m_valid = 1'b0; m_code = 0;
    end else begin
      cur = q[SS-1];
      ev = (pv.s && !cur.s) || (!pv.s && !cur.s && ((pv.o && !cur.o) || (pv.w && !cur.w)));
      lk = (m_lock > 0);
      if (lk) m_lock--;
      m_valid = 1'b0;
      if (ev && !lk) begin
        k = kf(int'(cur.a));
        if (!cur.w) m_step = 0;
        else if (m_step == 5) begin
          hit = -1;
          for (int c = 0; c < 4; c++) if (k == kf(cmds[c])) hit = c;
          if (hit >= 0) begin
            m_valid = 1'b1; m_code = hit; m_step = 0;
            m_lock = (hit < 2) ? PC + XC : PC;
          end else m_step = (k == kf(pre[0])) ? 1 : 0;
        end
        else if (k == kf(pre[m_step])) m_step++;
        else m_step = (k == kf(pre[0])) ? 1 : 0;
      end
      pv = cur;
      void'(q.pop_back());
      q.push_front('{s: sel_n, w: wr_n, o: oe_n, a: addr});
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 cmd_valid vs model", int'(cmd_valid), int'(m_valid));
      chk("R3 cmd_code vs model", int'(cmd_code), m_code);
      chk("R8 seq_busy vs model", int'(seq_busy), int'(m_step != 0));
      chk("R9 lockout vs model", int'(lockout), int'(m_lock > 0));
      if (cmd_valid) begin pulses++; last_code = int'(cmd_code); end
      if (lockout) lock_cnt++;
    end
  end

  // ---------------- bus stimulus ----------------
  task automatic rd_sel(int a, bit oe_low);
    @(negedge clk); addr = AW'(a); wr_n = 1'b1; oe_n = !oe_low;
    @(negedge clk); sel_n = 1'b0;
    repeat (2) @(negedge clk);
    sel_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_oe(int a);
    @(negedge clk); addr = AW'(a);
    @(negedge clk); oe_n = 1'b0;
    repeat (2) @(negedge clk);
    oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cyc(int a);
    @(negedge clk); addr = AW'(a);
    @(negedge clk); sel_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (SS + PC + XC + 6) @(negedge clk);
  endtask

  task automatic full_seq(int c, int xmask);
    for (int i = 0; i < 5; i++) rd_sel(pre[i] ^ xmask, 1'b0);
    rd_sel(cmds[c] ^ xmask, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmd_valid in reset", int'(cmd_valid), 0);
    chk("R1 seq_busy in reset", int'(seq_busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lockout after reset", int'(lockout), 0);
    chk("R1 cmd_code after reset", int'(cmd_code), 0);

    // R3 / R7: every command, select-controlled with output enable high
    for (int c = 0; c < 4; c++) begin
      pulses = 0; lock_cnt = 0;
      full_seq(c, 0);
      settle();
      chk("R3 one pulse per command", pulses, 1);
      chk("R3 command code", last_code, c);
      chk("R9 lockout length", lock_cnt, (c < 2) ? PC + XC : PC);
    end

    // R7: output-enable controlled reads under a held select
    pulses = 0;
    @(negedge clk); addr = AW'(pre[0]);
    @(negedge clk); sel_n = 1'b0;
    for (int i = 1; i < 5; i++) rd_oe(pre[i]);
    rd_oe(cmds[1]);
    @(negedge clk); sel_n = 1'b1;
    settle();
    chk("R7 output-enable clocked recall", pulses, 1);
    chk("R7 recall code", last_code, 1);

    // R7: steady select, address changes only -> no cycles
    pulses = 0;
    @(negedge clk); addr = '0;
    @(negedge clk); sel_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); addr = AW'((i < 5) ? pre[i] : cmds[0]);
      repeat (2) @(negedge clk);
    end
    @(negedge clk); sel_n = 1'b1;
    settle();
    chk("R7 steady strobes give no pulse", pulses, 0);

    // R2: bits outside [14:2] flipped
    pulses = 0;
    full_seq(2, 'hF8003);
    settle();
    chk("R2 dont-care bits ignored", pulses, 1);
    chk("R2 code with dont-care bits", last_code, 2);

    // R8 / R4: busy mid-sequence, then write abort
    for (int i = 0; i < 3; i++) rd_sel(pre[i], 1'b1);
    chk("R8 busy after three prefixes", int'(seq_busy), 1);
    wr_cyc(pre[3]);
    repeat (SS + 2) @(negedge clk);
    chk("R4 busy cleared by write", int'(seq_busy), 0);
    settle();

    // R4: write at each position
    for (int p = 0; p < 6; p++) begin
      pulses = 0;
      for (int i = 0; i < 6; i++) begin
        if (i == p) wr_cyc((i < 5) ? pre[i] : cmds[3]);
        else rd_sel((i < 5) ? pre[i] : cmds[3], 1'b0);
      end
      settle();
      chk("R4 write abort position", pulses, 0);
    end

    // R5: wrong read at each position
    for (int p = 0; p < 6; p++) begin
      pulses = 0;
      for (int i = 0; i < 6; i++) begin
        if (i == p) rd_sel('h1234, 1'b0);
        else rd_sel((i < 5) ? pre[i] : cmds[0], 1'b0);
      end
      settle();
      chk("R5 wrong read aborts", pulses, 0);
    end

    // R5: first prefix mid-sequence restarts at step one
    pulses = 0;
    for (int i = 0; i < 3; i++) rd_sel(pre[i], 1'b0);
    full_seq(3, 0);
    settle();
    chk("R5 restart on first prefix", pulses, 1);
    chk("R5 restart code", last_code, 3);

    // R6: unknown sixth address
    pulses = 0;
    for (int i = 0; i < 5; i++) rd_sel(pre[i], 1'b0);
    rd_sel('h5A5A, 1'b0);
    repeat (SS + 2) @(negedge clk);
    chk("R6 idle after bad command", int'(seq_busy), 0);
    settle();
    chk("R6 no pulse on bad command", pulses, 0);

    // R9: reads inside lockout are ignored
    pulses = 0;
    full_seq(0, 0);
    for (int i = 0; i < 5; i++) rd_sel(pre[i], 1'b0);
    rd_sel(cmds[2], 1'b0);
    settle();
    chk("R9 reads in lockout ignored", pulses, 1);
    chk("R9 only first command", last_code, 0);

    finish_up();
  end

endmodule